// File: doc/BRIEF.md
# Register transaction executor

This block carries out one already-decoded register-access transaction at a time against a small word-addressed memory and emits the reply words for it. A command carries a type, a word count, a transaction ID and a start address; any words the transaction needs (data to store, an addend, or a pair of mask terms) follow on a separate valid/ready operand stream. The block answers on a reply stream with a header word, followed by read data where the transaction returns any.

Six transaction kinds are served: reads and writes that step the address after every word, reads and writes that stay on one address, a read-modify-write that adds, and a read-modify-write that clears and sets bits. The memory is a single-port synchronous RAM, so a read-modify-write takes one read cycle and one write cycle, and the operand stream is held off during both. Each transaction also presents the header it received and the header it answered with on a history port, for status tracking by a neighbouring block.

Top module: `reg_txn_exec`

## Requirements
- R1: Every header word is laid out as version 4'h2 in bits 31:28, ID in 27:16, word count in 15:8, type in 7:4 and info code in 3:0. Reply headers of known types carry info 0, and the request header shown on the history port carries info 4'hF.
- R2: Type 0 (stepping read) of N words replies with a header of count N, then the N words stored at the start address, start+1, start+2 and so on.
- R3: Type 2 (fixed read) of N words replies with a header of count N, then N copies of the word at the start address.
- R4: Type 1 (stepping write) of N words takes N operand words, stores word k at start+k, and replies with one header word of count N (N may be 0).
- R5: Type 3 (fixed write) stores all N operand words at the start address, so the last one remains, and replies with one header of count N.
- R6: Type 5 (add) takes one operand word, replies with a header then the word as it was before the change, and stores old plus operand, modulo 2^32.
- R7: Type 4 (bit mask) takes two operand words, the AND term first and then the OR term, replies with a header then the old word, and stores (old AND and-term) OR or-term.
- R8: Both read-modify-write replies declare a count of 1, whatever count the request carried.
- R9: Types 6 to 15 get a single reply header with count 0 and info 1, consume no operand word and leave the memory unchanged.
- R10: Only the low MEM_AW bits of the address are used, and a stepping address wraps within that space.
- R11: A new command is accepted only when no transaction is in progress, and the operand stream accepts exactly as many words as the transaction type needs, none while a reply word is being sent or a read-modify-write is in progress.
- R12: Each transaction raises the history valid exactly once, in the cycle its reply header is on the reply stream, with the request header and that reply header.
- R13: A read with count 0 replies with the header alone, marked as the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Command accepted on this edge when valid |
| cmd_type_i | input | 4 | Transaction type code |
| cmd_count_i | input | 8 | Word count of the request |
| cmd_id_i | input | 12 | Transaction ID |
| cmd_addr_i | input | 32 | Start address, masked to MEM_AW bits |
| wr_valid_i | input | 1 | Operand word present |
| wr_ready_o | output | 1 | Operand word accepted on this edge when valid |
| wr_data_i | input | 32 | Operand word |
| rsp_valid_o | output | 1 | Reply word present |
| rsp_data_o | output | 32 | Reply word (header or data) |
| rsp_last_o | output | 1 | Last reply word of the transaction |
| hist_valid_o | output | 1 | History entry present |
| hist_rx_o | output | 32 | Request header of the transaction |
| hist_tx_o | output | 32 | Reply header of the transaction |

## Verification
The bench sweeps every start address of a 16-word memory with several counts, so stepping reads and writes that run past the top of the space are covered; a design that failed to wrap would read or overwrite the wrong words and the returned data would differ from the model. Read-modify-write runs at every address with an addend that overflows and with masks that both clear and set bits; returning the new value instead of the old one, or copying the request count into the header, shows up as a wrong reply word. Every operand beat is offered a surplus word that should never be taken, which catches a design that consumes operands for unknown types or during the read-modify-write cycles. Zero-count reads and writes check that the header alone is sent and marked last.

// File: rtl/reg_txn_pkg.sv
package reg_txn_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ID_W   = 12;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned TYPE_W = 4;

  localparam logic [3:0] PROTO_VER = 4'h2;
  localparam logic [3:0] INFO_REQ  = 4'hF;
  localparam logic [3:0] INFO_OK   = 4'h0;
  localparam logic [3:0] INFO_BAD  = 4'h1;

  localparam logic [TYPE_W-1:0] T_RD_INC   = 4'd0;
  localparam logic [TYPE_W-1:0] T_WR_INC   = 4'd1;
  localparam logic [TYPE_W-1:0] T_RD_FIX   = 4'd2;
  localparam logic [TYPE_W-1:0] T_WR_FIX   = 4'd3;
  localparam logic [TYPE_W-1:0] T_RMW_BITS = 4'd4;
  localparam logic [TYPE_W-1:0] T_RMW_SUM  = 4'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_HDR, ST_RD_DATA, ST_WR_DATA, ST_OPND, ST_RMW_RD, ST_RMW_WR, ST_ERR
  } st_e;

  function automatic logic [WORD_W-1:0] mk_hdr(input logic [ID_W-1:0] id,
                                               input logic [CNT_W-1:0] cnt,
                                               input logic [TYPE_W-1:0] typ,
                                               input logic [3:0] info);
    return {PROTO_VER, id, cnt, typ, info};
  endfunction
endpackage

// File: rtl/reg_txn_ram.sv
module reg_txn_ram #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  // read-first single port
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/reg_txn_hdr.sv
module reg_txn_hdr
  import reg_txn_pkg::*;
(
  input  logic [TYPE_W-1:0] typ_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ID_W-1:0]   id_i,
  output logic [WORD_W-1:0] rx_hdr_o,
  output logic [WORD_W-1:0] tx_hdr_o
);
  logic             known;
  logic             rmw;
  logic [CNT_W-1:0] tx_cnt;

  always_comb begin
    known  = (typ_i <= T_RMW_SUM);
    rmw    = (typ_i == T_RMW_BITS) || (typ_i == T_RMW_SUM);
    tx_cnt = !known ? '0 : rmw ? CNT_W'(1) : cnt_i;
    rx_hdr_o = mk_hdr(id_i, cnt_i, typ_i, INFO_REQ);
    tx_hdr_o = mk_hdr(id_i, tx_cnt, typ_i, known ? INFO_OK : INFO_BAD);
  end
endmodule

// File: rtl/reg_txn_seq.sv
module reg_txn_seq
  import reg_txn_pkg::*;
#(
  parameter int unsigned MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [TYPE_W-1:0] cmd_type_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [MEM_AW-1:0] cmd_addr_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              rsp_last_o,
  output logic              hist_valid_o,
  output logic [TYPE_W-1:0] typ_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ID_W-1:0]   id_o,
  input  logic [WORD_W-1:0] tx_hdr_i,
  output logic              ram_we_o,
  output logic [MEM_AW-1:0] ram_addr_o,
  output logic [WORD_W-1:0] ram_wdata_o,
  input  logic [WORD_W-1:0] ram_rdata_i
);
  st_e               state_q;
  logic [TYPE_W-1:0] typ_q;
  logic [CNT_W-1:0]  cnt_q, left_q;
  logic [ID_W-1:0]   id_q;
  logic [MEM_AW-1:0] addr_q, step;
  logic [WORD_W-1:0] opa_q, opb_q;
  logic              op_idx_q;

  assign typ_o = typ_q;
  assign cnt_o = cnt_q;
  assign id_o  = id_q;
  assign step  = MEM_AW'((typ_q == T_RD_INC) || (typ_q == T_WR_INC));

  always_comb begin
    cmd_ready_o  = 1'b0;
    wr_ready_o   = 1'b0;
    rsp_valid_o  = 1'b0;
    rsp_data_o   = tx_hdr_i;
    rsp_last_o   = 1'b0;
    hist_valid_o = 1'b0;
    ram_we_o     = 1'b0;
    ram_addr_o   = addr_q;
    ram_wdata_o  = wr_data_i;
    unique case (state_q)
      ST_IDLE: cmd_ready_o = 1'b1;
      ST_RD_HDR: begin
        rsp_valid_o  = 1'b1;
        hist_valid_o = 1'b1;
        rsp_last_o   = (cnt_q == '0);
      end
      ST_RD_DATA: begin
        rsp_valid_o = 1'b1;
        rsp_data_o  = ram_rdata_i;
        rsp_last_o  = (left_q == CNT_W'(1));
      end
      ST_WR_DATA: begin
        if (left_q == '0) begin
          rsp_valid_o  = 1'b1;
          hist_valid_o = 1'b1;
          rsp_last_o   = 1'b1;
        end else begin
          wr_ready_o = 1'b1;
          ram_we_o   = wr_valid_i;
        end
      end
      ST_OPND: wr_ready_o = 1'b1;
      ST_RMW_RD: begin
        rsp_valid_o  = 1'b1;
        hist_valid_o = 1'b1;
      end
      ST_RMW_WR: begin
        rsp_valid_o = 1'b1;
        rsp_data_o  = ram_rdata_i;
        rsp_last_o  = 1'b1;
        ram_we_o    = 1'b1;
        ram_wdata_o = (typ_q == T_RMW_SUM) ? ram_rdata_i + opa_q
                                           : (ram_rdata_i & opa_q) | opb_q;
      end
      default: begin
        rsp_valid_o  = 1'b1;
        hist_valid_o = 1'b1;
        rsp_last_o   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      typ_q    <= '0;
      cnt_q    <= '0;
      left_q   <= '0;
      id_q     <= '0;
      addr_q   <= '0;
      opa_q    <= '0;
      opb_q    <= '0;
      op_idx_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          typ_q    <= cmd_type_i;
          cnt_q    <= cmd_count_i;
          left_q   <= cmd_count_i;
          id_q     <= cmd_id_i;
          addr_q   <= cmd_addr_i;
          op_idx_q <= 1'b0;
          if (cmd_type_i == T_RD_INC || cmd_type_i == T_RD_FIX)      state_q <= ST_RD_HDR;
          else if (cmd_type_i == T_WR_INC || cmd_type_i == T_WR_FIX) state_q <= ST_WR_DATA;
          else if (cmd_type_i <= T_RMW_SUM)                          state_q <= ST_OPND;
          else                                                       state_q <= ST_ERR;
        end
        ST_RD_HDR: begin
          addr_q  <= addr_q + step;
          state_q <= (cnt_q == '0) ? ST_IDLE : ST_RD_DATA;
        end
        ST_RD_DATA: begin
          if (left_q == CNT_W'(1)) state_q <= ST_IDLE;
          else begin
            left_q <= left_q - CNT_W'(1);
            addr_q <= addr_q + step;
          end
        end
        ST_WR_DATA: begin
          if (left_q == '0) state_q <= ST_IDLE;
          else if (wr_valid_i) begin
            left_q <= left_q - CNT_W'(1);
            addr_q <= addr_q + step;
          end
        end
        ST_OPND: if (wr_valid_i) begin
          if (op_idx_q) opb_q <= wr_data_i;
          else          opa_q <= wr_data_i;
          op_idx_q <= 1'b1;
          if (typ_q == T_RMW_SUM || op_idx_q) state_q <= ST_RMW_RD;
        end
        ST_RMW_RD: state_q <= ST_RMW_WR;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  a_r11_no_intake_while_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (!cmd_ready_o && !wr_ready_o));
  a_r12_single_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_valid_o |=> !hist_valid_o);
  a_r2_last_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |=> cmd_ready_o);
  a_r6_rmw_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RMW_RD) |=> (rsp_valid_o && rsp_last_o && ram_we_o && !wr_ready_o));
endmodule

// File: rtl/reg_txn_exec.sv
module reg_txn_exec
  import reg_txn_pkg::*;
#(
  parameter int unsigned MEM_AW = 6,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [TYPE_W-1:0] cmd_type_i,
  input  logic [CNT_W-1:0]  cmd_count_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              rsp_last_o,
  output logic              hist_valid_o,
  output logic [WORD_W-1:0] hist_rx_o,
  output logic [WORD_W-1:0] hist_tx_o
);
  logic [TYPE_W-1:0] typ;
  logic [CNT_W-1:0]  cnt;
  logic [ID_W-1:0]   id;
  logic              ram_we;
  logic [MEM_AW-1:0] ram_addr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^cmd_addr_i[ADDR_W-1:MEM_AW];

  reg_txn_seq #(.MEM_AW(MEM_AW)) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_type_i, .cmd_count_i, .cmd_id_i,
    .cmd_addr_i  (cmd_addr_i[MEM_AW-1:0]),
    .wr_valid_i, .wr_ready_o, .wr_data_i,
    .rsp_valid_o, .rsp_data_o, .rsp_last_o, .hist_valid_o,
    .typ_o       (typ),
    .cnt_o       (cnt),
    .id_o        (id),
    .tx_hdr_i    (hist_tx_o),
    .ram_we_o    (ram_we),
    .ram_addr_o  (ram_addr),
    .ram_wdata_o (ram_wdata),
    .ram_rdata_i (ram_rdata)
  );

  reg_txn_hdr u_hdr (
    .typ_i    (typ),
    .cnt_i    (cnt),
    .id_i     (id),
    .rx_hdr_o (hist_rx_o),
    .tx_hdr_o (hist_tx_o)
  );

  reg_txn_ram #(.AW(MEM_AW), .DW(WORD_W)) u_ram (
    .clk_i,
    .we_i    (ram_we),
    .addr_i  (ram_addr),
    .wdata_i (ram_wdata),
    .rdata_o (ram_rdata)
  );

  a_r8_rmw_one_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_valid_o && (hist_rx_o[7:4] == T_RMW_BITS || hist_rx_o[7:4] == T_RMW_SUM))
      |-> (hist_tx_o[15:8] == 8'd1 && !rsp_last_o));
  a_r9_unknown_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_valid_o && hist_tx_o[3:0] == INFO_BAD) |-> (rsp_last_o && hist_tx_o[15:8] == 8'd0));
  a_r13_empty_read_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_valid_o && (hist_rx_o[7:4] == T_RD_INC || hist_rx_o[7:4] == T_RD_FIX)
      && hist_rx_o[15:8] == 8'd0) |-> rsp_last_o);
endmodule

// File: tb/tb_reg_txn_exec.sv
module tb_reg_txn_exec;
  localparam int MW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [3:0]  cmd_type = '0;
  logic [7:0]  cmd_count = '0;
  logic [11:0] cmd_id = '0;
  logic [31:0] cmd_addr = '0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [31:0] wr_data = '0;
  logic        rsp_valid, rsp_last, hist_valid;
  logic [31:0] rsp_data, hist_rx, hist_tx;

  always #5 clk = ~clk;

  reg_txn_exec #(.MEM_AW(4)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_type_i(cmd_type),
    .cmd_count_i(cmd_count), .cmd_id_i(cmd_id), .cmd_addr_i(cmd_addr),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_data_i(wr_data),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_last_o(rsp_last),
    .hist_valid_o(hist_valid), .hist_rx_o(hist_rx), .hist_tx_o(hist_tx)
  );

  int n_chk = 0, n_bad = 0;
  int done_cnt = 0, align_bad = 0, overlap_bad = 0;
  logic [31:0] rsp_q[$], exp_q[$], hrx_q[$], htx_q[$];
  logic [31:0] model [MW];
  logic [31:0] opw [MW];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [11:0] id, input int cnt,
                                      input logic [3:0] t, input logic [3:0] info);
    return {4'h2, id, 8'(cnt), t, info};
  endfunction

  // monitor at the falling edge
  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_q.push_back(rsp_data);
      if (cmd_ready) overlap_bad++;
      if (rsp_last) done_cnt++;
    end
    if (hist_valid) begin
      hrx_q.push_back(hist_rx);
      htx_q.push_back(hist_tx);
      if (!(rsp_valid && rsp_data == hist_tx)) align_bad++;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic run_txn(input logic [3:0] t, input int n, input logic [11:0] id,
                         input logic [31:0] a, input string tag);
    int am = int'(a[3:0]);
    int nops = 0, extra = 0, prev = done_cnt, ob = overlap_bad, ab = align_bad;
    logic [31:0] old;
    exp_q.delete(); rsp_q.delete(); hrx_q.delete(); htx_q.delete();
    case (t)
      4'd0, 4'd2: begin
        exp_q.push_back(hdr(id, n, t, 4'h0));
        for (int i = 0; i < n; i++) exp_q.push_back(model[(am + (t == 4'd0 ? i : 0)) % MW]);
      end
      4'd1, 4'd3: begin
        nops = n;
        for (int i = 0; i < n; i++) model[(am + (t == 4'd1 ? i : 0)) % MW] = opw[i];
        exp_q.push_back(hdr(id, n, t, 4'h0));
      end
      4'd4, 4'd5: begin
        nops = (t == 4'd5) ? 1 : 2;
        old = model[am];
        exp_q.push_back(hdr(id, 1, t, 4'h0));
        exp_q.push_back(old);
        model[am] = (t == 4'd5) ? old + opw[0] : ((old & opw[0]) | opw[1]);
      end
      default: exp_q.push_back(hdr(id, 0, t, 4'h1));
    endcase
    cmd_valid = 1'b1; cmd_type = t; cmd_count = 8'(n); cmd_id = id; cmd_addr = a;
    while (!cmd_ready) step();
    step();
    cmd_valid = 1'b0;
    for (int k = 0; k < nops; k++) begin
      wr_valid = 1'b1; wr_data = opw[k];
      while (!wr_ready) step();
      step();
    end
    // surplus word that must never be taken (R11)
    wr_valid = 1'b1; wr_data = 32'hDEAD_BEEF;
    while (done_cnt == prev) begin
      if (wr_ready) extra++;
      step();
    end
    wr_valid = 1'b0;
    step();
    chk(rsp_q.size() == exp_q.size(), {tag, " reply length"}, 32'(rsp_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++)
      if (i < rsp_q.size()) chk(rsp_q[i] == exp_q[i], {tag, (i == 0) ? " R1 header" : " data"}, rsp_q[i], exp_q[i]);
    chk(hrx_q.size() == 1, "R12 history count", 32'(hrx_q.size()), 32'd1);
    if (hrx_q.size() == 1) begin
      chk(hrx_q[0] == hdr(id, n, t, 4'hF), "R12 request header", hrx_q[0], hdr(id, n, t, 4'hF));
      chk(htx_q[0] == exp_q[0], "R12 reply header", htx_q[0], exp_q[0]);
    end
    chk(align_bad == ab, "R12 history aligned with header", 32'(align_bad - ab), 32'd0);
    chk(extra == 0 && overlap_bad == ob, "R11 surplus intake", 32'(extra), 32'd0);
  endtask

  task automatic full_read(input string tag);
    run_txn(4'd0, MW, 12'h7FF, 32'd0, tag);
  endtask

  initial begin
    step(); step();
    chk(cmd_ready == 1'b1, "R11 reset ready", 32'(cmd_ready), 32'd1);
    chk(rsp_valid == 1'b0 && hist_valid == 1'b0, "R12 reset quiet", 32'({rsp_valid, hist_valid}), 32'd0);
    rst_n = 1'b1;
    step();
    chk(cmd_ready == 1'b1 && wr_ready == 1'b0, "R11 idle after reset", 32'({cmd_ready, wr_ready}), 32'd2);

    // R4: fill the whole space
    for (int i = 0; i < MW; i++) opw[i] = (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
    run_txn(4'd1, MW, 12'h001, 32'd0, "R4 fill");
    full_read("R2 readback");

    // R2 R10 R13: stepping reads from every address, with wrap
    for (int a = 0; a < MW; a++)
      foreach (opw[j]) if (j < 4) run_txn(4'd0, (j == 0) ? 0 : 2 * j - 1, 12'(a * 4 + j), 32'(a),
                                          (j == 0) ? "R13 empty read" : "R2 R10 stepping read");
    // R3 and R13 on the fixed read
    for (int a = 0; a < MW; a++) run_txn(4'd2, 3, 12'(a), 32'(a), "R3 fixed read");
    run_txn(4'd2, 0, 12'hABC, 32'd9, "R13 empty fixed read");

    // R5: fixed write leaves the last word
    for (int i = 0; i < 4; i++) opw[i] = 32'h5000_0000 + 32'(i);
    run_txn(4'd3, 4, 12'h123, 32'd5, "R5 fixed write");
    full_read("R5 readback");

    // R10: high address bits ignored, stepping write wraps
    for (int i = 0; i < 4; i++) opw[i] = 32'h1000_0000 * 32'(i + 1) + 32'h77;
    run_txn(4'd1, 4, 12'h456, 32'hFFFF_FFFE, "R10 masked write");
    full_read("R10 readback");
    run_txn(4'd0, 3, 12'h457, 32'h1234_567F, "R10 masked read");

    // R4: zero-count write
    run_txn(4'd1, 0, 12'h0EE, 32'd3, "R4 empty write");

    // R6 R8: add at every address, overflow included
    for (int a = 0; a < MW; a++) begin
      opw[0] = 32'hFFFF_FFF0 + 32'(a * 3);
      run_txn(4'd5, 7, 12'(12'h300 + a), 32'(a), "R6 R8 add");
    end
    full_read("R6 readback");

    // R7 R8: masked update at every address
    for (int a = 0; a < MW; a++) begin
      opw[0] = 32'hF0F0_FF00;
      opw[1] = 32'(a) << 4;
      run_txn(4'd4, 0, 12'(12'h400 + a), 32'(a), "R7 R8 bit mask");
    end
    full_read("R7 readback");

    // R9: every unknown type
    for (int t = 6; t < 16; t++) run_txn(4'(t), 3, 12'(12'h500 + t), 32'(t), "R9 unknown");
    full_read("R9 memory unchanged");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule